// File: doc/BRIEF.md
# Trimmed Seconds Prescaler

This block turns a stream of oscillator-cycle enables, nominally 32,768 per second, into a one-cycle pulse once per second. It also applies a digital trim for crystal error. It does not touch the oscillator. Instead, it occasionally moves the carry point of its divide-by-256 stage. This makes one chosen second shorter, which speeds the clock up, or longer, which slows it down. The correction schedule repeats every 64 minutes. A 5-bit magnitude selects how many minutes of that schedule carry a corrected second, and a sign bit selects the direction.

A second output serves production calibration. When the frequency test is enabled and the divider is running, it pulls a shared line low and releases it at a fixed 512 Hz with equal halves, tapped from inside the divider chain. Test equipment can then measure the raw oscillator error.

A stop input clears the divider and the correction position and holds them. When stop is released, counting begins again from the start of a second, at minute zero of the correction schedule.

Top module: `trim_prescaler`

## Requirements
- R1: With no trim active, `tick_1hz` is a single-cycle pulse after every 2^(STAGE_W+UPPER_W) oscillator enables (32,768 by default).
- R2: The divider advances only in clock cycles where `osc_en` is 1. A cycle without it changes no count.
- R3: With `cal_sign` = 1, a corrected second is shorter by one full stage count, 2^STAGE_W enables (256 by default).
- R4: With `cal_sign` = 0, a corrected second is longer by half a stage count, 2^(STAGE_W-1) enables (128 by default).
- R5: Only second 0 of a minute can be corrected, and only in minutes 0 to 2N-1 of the schedule, where N is the value of `cal_mag`. A magnitude of 0 corrects nothing.
- R6: A minute is SEC_PER_MIN ticks (60 by default). The schedule is 2^(MAG_W+1) minutes (64 by default) and then restarts at minute 0.
- R7: While `stop` is 1, no tick is produced and both the divider and the schedule position are held at zero. The first tick after release comes exactly one second later, and that second counts as second 0 of minute 0.
- R8: With `ftest_en` = 1, `stop` = 0 and no trim active, `ft_pull_low` alternates with a period of 2^(FT_BIT+1) enables and a 50% duty cycle (512 Hz by default).
- R9: `ft_pull_low` is 0 (line released) in the cycle after `ftest_en` is 0 or `stop` is 1.
- R10: While `rst_n` is low, `tick_1hz` and `ft_pull_low` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_en | input | 1 | One oscillator cycle has elapsed |
| stop | input | 1 | Clear and hold the divider and schedule |
| ftest_en | input | 1 | Enable the frequency-test output |
| cal_sign | input | 1 | 1 shortens corrected seconds, 0 lengthens them |
| cal_mag | input | MAG_W | Trim magnitude N |
| tick_1hz | output | 1 | One-cycle pulse per second |
| ft_pull_low | output | 1 | 1 pulls the test line low, 0 releases it |

## Verification
The bench builds the block with STAGE_W=3, UPPER_W=3, SEC_PER_MIN=4, FT_BIT=2 and keeps MAG_W at 5. With these values a second is 64 enables, a corrected second is 56 or 68, and the test period is 8. A full 64-minute schedule then takes about 16,000 cycles. This makes the full-scale magnitude, the uncorrected last two minutes and the schedule wrap reachable within the run. The same default magnitude width keeps the schedule length the same as in the full-size block.

// File: rtl/trim_prescaler_pkg.sv
package trim_prescaler_pkg;
   typedef enum logic [1:0] {
      CAL_NONE  = 2'd0,
      CAL_SHORT = 2'd1,
      CAL_LONG  = 2'd2
   } cal_mode_e;
endpackage

// File: rtl/prescale_divider.sv
module prescale_divider
   import trim_prescaler_pkg::*;
#(
   parameter int STAGE_W = 8,
   parameter int UPPER_W = 7,
   parameter int FT_BIT  = 5
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      osc_en,
   input  logic      stop,
   input  cal_mode_e mode,
   output logic      tick,
   output logic      tap
);
   localparam logic [STAGE_W-1:0] LO_MAX  = {STAGE_W{1'b1}};
   localparam logic [STAGE_W-1:0] LO_HALF = {1'b1, {(STAGE_W-1){1'b0}}};
   localparam logic [UPPER_W-1:0] HI_MAX  = {UPPER_W{1'b1}};
   localparam logic [UPPER_W-1:0] HI_SKIP = UPPER_W'(2);

   if (STAGE_W < 2) begin : g_bad_stage
      $error("STAGE_W must be at least 2");
   end
   if (UPPER_W < 2) begin : g_bad_upper
      $error("UPPER_W must be at least 2");
   end
   if (FT_BIT >= STAGE_W + UPPER_W) begin : g_bad_ft
      $error("FT_BIT must lie inside the divider");
   end

   logic [STAGE_W-1:0] lo_q;
   logic [UPPER_W-1:0] hi_q;
   logic               ext_q;
   logic               tick_q;
   logic               lo_wrap;
   logic               blank;

   assign lo_wrap = (lo_q == LO_MAX);
   assign blank   = lo_wrap && (mode == CAL_LONG) && (hi_q == '0) && !ext_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q   <= '0;
         hi_q   <= '0;
         ext_q  <= 1'b0;
         tick_q <= 1'b0;
      end else if (stop) begin
         lo_q   <= '0;
         hi_q   <= '0;
         ext_q  <= 1'b0;
         tick_q <= 1'b0;
      end else begin
         tick_q <= 1'b0;
         if (osc_en) begin
            if (!lo_wrap) begin
               lo_q <= lo_q + 1'b1;
            end else if (blank) begin
               lo_q  <= LO_HALF;
               ext_q <= 1'b1;
            end else begin
               lo_q  <= '0;
               ext_q <= 1'b0;
               if (hi_q == HI_MAX) begin
                  hi_q   <= '0;
                  tick_q <= 1'b1;
               end else if ((mode == CAL_SHORT) && (hi_q == '0)) begin
                  hi_q <= HI_SKIP;
               end else begin
                  hi_q <= hi_q + 1'b1;
               end
            end
         end
      end
   end

   assign tick = tick_q;

   if (FT_BIT < STAGE_W) begin : g_tap_lo
      assign tap = lo_q[FT_BIT];
   end else begin : g_tap_hi
      assign tap = hi_q[FT_BIT-STAGE_W];
   end

   assert_single_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q |=> !tick_q);
   assert_hold_no_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_en && !stop) |=> ($stable(lo_q) && $stable(hi_q)));
   assert_ext_first_stage_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ext_q |-> (hi_q == '0));
   assert_stop_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (!tick_q && lo_q == '0 && hi_q == '0));
endmodule

// File: rtl/prescale_cal_seq.sv
module prescale_cal_seq
   import trim_prescaler_pkg::*;
#(
   parameter int SEC_PER_MIN = 60,
   parameter int MAG_W       = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stop,
   input  logic             tick,
   input  logic             cal_sign,
   input  logic [MAG_W-1:0] cal_mag,
   output cal_mode_e        mode
);
   localparam int MIN_W = MAG_W + 1;
   localparam int SEC_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
   localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);

   if (SEC_PER_MIN < 2) begin : g_bad_min
      $error("SEC_PER_MIN must be at least 2");
   end
   if (MAG_W < 1) begin : g_bad_mag
      $error("MAG_W must be at least 1");
   end

   logic [SEC_W-1:0] sec_q;
   logic [MIN_W-1:0] min_q;
   logic             in_window;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q <= '0;
         min_q <= '0;
      end else if (stop) begin
         sec_q <= '0;
         min_q <= '0;
      end else if (tick) begin
         if (sec_q == SEC_LAST) begin
            sec_q <= '0;
            min_q <= min_q + 1'b1;
         end else begin
            sec_q <= sec_q + 1'b1;
         end
      end
   end

   assign in_window = (cal_mag != '0) && (sec_q == '0) && (min_q < {cal_mag, 1'b0});

   always_comb begin
      if (!in_window)    mode = CAL_NONE;
      else if (cal_sign) mode = CAL_SHORT;
      else               mode = CAL_LONG;
   end

   assert_sec_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sec_q <= SEC_LAST);
   assert_sec_steps_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !stop) |=> $stable(sec_q));
   assert_stop_clears_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (sec_q == '0 && min_q == '0));
endmodule

// File: rtl/prescale_ft_drive.sv
module prescale_ft_drive (
   input  logic clk,
   input  logic rst_n,
   input  logic stop,
   input  logic ftest_en,
   input  logic tap,
   output logic pull_low
);
   logic pull_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pull_q <= 1'b0;
      else        pull_q <= ftest_en && !stop && tap;
   end

   assign pull_low = pull_q;

   assert_released_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ftest_en || stop) |=> !pull_q);
endmodule

// File: rtl/trim_prescaler.sv
module trim_prescaler
   import trim_prescaler_pkg::*;
#(
   parameter int STAGE_W     = 8,
   parameter int UPPER_W     = 7,
   parameter int SEC_PER_MIN = 60,
   parameter int MAG_W       = 5,
   parameter int FT_BIT      = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             osc_en,
   input  logic             stop,
   input  logic             ftest_en,
   input  logic             cal_sign,
   input  logic [MAG_W-1:0] cal_mag,
   output logic             tick_1hz,
   output logic             ft_pull_low
);
   cal_mode_e mode;
   logic      tick;
   logic      tap;

   prescale_cal_seq #(
      .SEC_PER_MIN(SEC_PER_MIN),
      .MAG_W      (MAG_W)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .stop    (stop),
      .tick    (tick),
      .cal_sign(cal_sign),
      .cal_mag (cal_mag),
      .mode    (mode)
   );

   prescale_divider #(
      .STAGE_W(STAGE_W),
      .UPPER_W(UPPER_W),
      .FT_BIT (FT_BIT)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .osc_en(osc_en),
      .stop  (stop),
      .mode  (mode),
      .tick  (tick),
      .tap   (tap)
   );

   prescale_ft_drive u_ft (
      .clk     (clk),
      .rst_n   (rst_n),
      .stop    (stop),
      .ftest_en(ftest_en),
      .tap     (tap),
      .pull_low(ft_pull_low)
   );

   assign tick_1hz = tick;

   assert_reset_quiet_R10: assert property (@(posedge clk)
      !rst_n |-> (!tick_1hz && !ft_pull_low));
endmodule

// File: tb/trim_prescaler_bench.sv
module trim_prescaler_bench;
   localparam int STAGE_W = 3;
   localparam int UPPER_W = 3;
   localparam int SPM     = 4;
   localparam int MAG_W   = 5;
   localparam int FT_BIT  = 2;
   localparam int SEC_LEN = 1 << (STAGE_W + UPPER_W);
   localparam int SHORT_LEN = SEC_LEN - (1 << STAGE_W);
   localparam int LONG_LEN  = SEC_LEN + (1 << (STAGE_W - 1));
   localparam int CYC_MIN = 1 << (MAG_W + 1);

   // {sign, magnitude, seconds to measure}
   localparam logic [15:0] VEC [0:5] = '{
      {1'b0, 5'd0,  10'd12},
      {1'b1, 5'd1,  10'd12},
      {1'b0, 5'd1,  10'd12},
      {1'b1, 5'd3,  10'd28},
      {1'b0, 5'd31, 10'd260},
      {1'b1, 5'd31, 10'd260}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             osc_en = 1'b1;
   logic             stop = 1'b0;
   logic             ftest_en = 1'b0;
   logic             cal_sign = 1'b0;
   logic [MAG_W-1:0] cal_mag = '0;
   logic             tick_1hz;
   logic             ft_pull_low;
   logic             half_rate = 1'b0;
   int               n_checks = 0;
   int               n_errors = 0;
   bit               done = 1'b0;

   always #2 clk = ~clk;

   always @(negedge clk) if (half_rate) osc_en <= ~osc_en;

   trim_prescaler #(
      .STAGE_W(STAGE_W), .UPPER_W(UPPER_W), .SEC_PER_MIN(SPM),
      .MAG_W(MAG_W), .FT_BIT(FT_BIT)
   ) u_trim_prescaler (
      .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .stop(stop),
      .ftest_en(ftest_en), .cal_sign(cal_sign), .cal_mag(cal_mag),
      .tick_1hz(tick_1hz), .ft_pull_low(ft_pull_low)
   );

   task automatic check(input string req, input int actual, input int expected);
      n_checks++;
      if (actual != expected) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
      end
   endtask

   function automatic int exp_len(input logic sgn, input int mag, input int s);
      int m;
      m = (s / SPM) % CYC_MIN;
      if (mag != 0 && (s % SPM) == 0 && m < 2 * mag)
         return sgn ? SHORT_LEN : LONG_LEN;
      return SEC_LEN;
   endfunction

   // starts and ends at a negedge; counts posedges until tick is seen
   task automatic measure(output int n);
      n = 0;
      do begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end while (!tick_1hz && n < 1000);
   endtask

   task automatic restart();
      @(negedge clk);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
   endtask

   initial begin
      #(4 * 190000);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      int n, ones, toggles, ticks;
      logic prev;
      ftest_en = 1'b1;
      repeat (5) @(negedge clk);
      check("R10 tick in reset", int'(tick_1hz), 0);
      check("R10 ft in reset", int'(ft_pull_low), 0);
      ftest_en = 1'b0;
      rst_n = 1'b1;

      // vector table: R1 R3 R4 R5 R6
      for (int v = 0; v < 6; v++) begin
         @(negedge clk);
         stop = 1'b1;
         cal_sign = VEC[v][15];
         cal_mag = VEC[v][14:10];
         @(negedge clk);
         stop = 1'b0;
         for (int s = 0; s < int'(VEC[v][9:0]); s++) begin
            measure(n);
            check($sformatf("R1/R3/R4/R5/R6 vec%0d sec%0d", v, s), n,
                  exp_len(cal_sign, int'(cal_mag), s));
         end
      end

      // R7: stop mid-schedule, hold, then position restarts at minute 0
      cal_sign = 1'b1; cal_mag = 5'd1;
      restart();
      for (int s = 0; s < 6; s++) measure(n);
      repeat (10) @(negedge clk);
      stop = 1'b1;
      ticks = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (tick_1hz) ticks++;
      end
      check("R7 no tick while stopped", ticks, 0);
      stop = 1'b0;
      measure(n);
      check("R7 first second after release", n, SHORT_LEN);
      measure(n);
      check("R7 second after release", n, SEC_LEN);

      // R8: test output period and duty with no trim
      cal_mag = '0;
      ftest_en = 1'b1;
      restart();
      repeat (20) @(negedge clk);
      ones = 0; toggles = 0; prev = ft_pull_low;
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         if (ft_pull_low) ones++;
         if (ft_pull_low != prev) toggles++;
         prev = ft_pull_low;
      end
      check("R8 ft duty", ones, 32);
      check("R8 ft toggles", toggles, 64 / (1 << FT_BIT));

      // R9: released while stopped and while disabled
      stop = 1'b1;
      ones = 0;
      @(negedge clk);
      for (int i = 0; i < 32; i++) begin
         @(negedge clk);
         if (ft_pull_low) ones++;
      end
      check("R9 ft released while stopped", ones, 0);
      stop = 1'b0;
      ftest_en = 1'b0;
      ones = 0;
      @(negedge clk);
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         if (ft_pull_low) ones++;
      end
      check("R9 ft released when disabled", ones, 0);

      // R2: half-rate enables double the second in clock cycles
      restart();
      half_rate = 1'b1;
      measure(n);
      measure(n);
      check("R2 second at half enable rate", n, 2 * SEC_LEN);
      measure(n);
      check("R2 second at half enable rate again", n, 2 * SEC_LEN);
      half_rate = 1'b0;
      osc_en = 1'b1;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule